// File: doc/BRIEF.md
# Masked Element-Serial Vector Unit

This block runs integer vector operations one element per clock under the control of a per-element Boolean mask. It supports three operations. Subtract computes the difference of two source vectors into a destination array held inside the block. Compare-not-equal rebuilds the mask from a source vector and a scalar. Set-all forces every mask bit to one. A requested vector length sets how many element slots an operation visits. Slots run in ascending index order, and each slot takes one cycle whether or not its mask bit allows a write.

The surrounding pipeline raises a start request while the unit is idle. During each busy cycle it supplies the operand pair for the element index that the unit presents. It then waits for the one-cycle done pulse. Each processed element is reported on an element event port. The destination contents can be read through a combinational read port, and the mask is visible at all times.

Top module: `vmask_unit`

## Requirements
- R1: After reset, busy and done are low, all mask bits are 1, and every destination entry reads 0.
- R2: Subtract (op code 2'b00) with masking disabled writes destination entry i with (src_a - src_b) modulo 2^EW for every i below the effective length, and the element event reports that difference with its write flag at 1.
- R3: Subtract with masking enabled writes only entries whose mask bit is 1. Entries whose bit is 0 keep their old value, and their element event carries write flag 0.
- R4: An operation with effective length L keeps busy high for exactly L cycles, presenting indices 0 to L-1 in order. Done is high for the single cycle after the last element. The mask contents do not change this timing.
- R5: Compare-not-equal (op code 2'b01) sets mask bit i to 1 when src_a element i differs from the scalar and to 0 otherwise, for i below the effective length. Higher mask bits are left unchanged. The destination is untouched, and masking does not affect the compare.
- R6: Set-all (op code 2'b10) makes all MVL mask bits 1 whatever the length, and leaves the destination unchanged.
- R7: A start request made while busy is ignored. The running operation continues unchanged.
- R8: A length above MVL acts as MVL. A length of 0 produces a done pulse in the cycle after acceptance, processes no element and changes nothing.
- R9: With masking disabled, subtract writes every element below the length even where the mask holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Operation request, accepted when idle |
| op_i | input | 2 | 00 subtract, 01 compare-not-equal, 10 set-all, 11 no effect |
| mask_en_i | input | 1 | Apply the mask to subtract writes |
| vl_i | input | $clog2(MVL+1) | Requested vector length |
| scalar_i | input | EW | Scalar operand for compare |
| src_a_i | input | EW | First source element for the current index |
| src_b_i | input | EW | Second source element for the current index |
| busy_o | output | 1 | Element processing in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cur_idx_o | output | $clog2(MVL) | Element index whose operands are due this cycle |
| elem_valid_o | output | 1 | An element was processed at the previous edge |
| elem_idx_o | output | $clog2(MVL) | Index of that element |
| elem_we_o | output | 1 | Destination entry or mask bit was written |
| elem_res_o | output | EW | Difference for subtract, new mask bit for compare, 0 otherwise |
| mask_o | output | MVL | Current mask register |
| rd_idx_i | input | $clog2(MVL) | Destination read index |
| rd_data_o | output | EW | Destination entry at rd_idx_i |

## Verification
The hardest states to reach are those where the mask holds a mixed pattern from an earlier compare at the moment a masked subtract runs, and those where mask bits above a short compare's length must still hold values from a longer compare. The stimulus therefore chains a full-length compare, a shorter compare and then masked and unmasked subtracts, all against a bench model of mask and destination. A set-all request injected in the middle of a masked subtract checks that starts made while busy are dropped. A set-all that did take effect would change both the per-element write flags and the final mask.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [1:0] {
    VOP_SUB    = 2'b00,
    VOP_CMPNE  = 2'b01,
    VOP_SETALL = 2'b10,
    VOP_NONE   = 2'b11
  } vop_e;
endpackage

// File: rtl/vmu_seq.sv
module vmu_seq #(
  parameter int MVL = 16,
  parameter int IW  = $clog2(MVL),
  parameter int LW  = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] vl_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  logic          busy_q, done_q;
  logic [IW-1:0] idx_q, last_q;
  logic [LW-1:0] eff_vl;
  logic          at_last;

  assign eff_vl   = (vl_i > LW'(MVL)) ? LW'(MVL) : vl_i;
  assign accept_o = start_i && !busy_q;
  assign at_last  = busy_q && (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        if (eff_vl == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          last_q <= IW'(eff_vl - LW'(1));
        end
      end else if (busy_q) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> (busy_q && idx_q == $past(idx_q) + IW'(1)));
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q && !at_last) |=> (busy_q && idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: rtl/vmu_mask.sv
module vmu_mask #(
  parameter int MVL = 16,
  parameter int IW  = $clog2(MVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_all_i,
  input  logic           upd_en_i,
  input  logic [IW-1:0]  upd_idx_i,
  input  logic           upd_bit_i,
  output logic [MVL-1:0] mask_o
);
  logic [MVL-1:0] mask_q;

  for (genvar g = 0; g < MVL; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mask_q[g] <= 1'b1;
      else if (set_all_i)                           mask_q[g] <= 1'b1;
      else if (upd_en_i && upd_idx_i == IW'(g))     mask_q[g] <= upd_bit_i;
    end
  end

  assign mask_o = mask_q;

  // R5
  mask_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && !set_all_i) |=> (mask_q[$past(upd_idx_i)] == $past(upd_bit_i)));
  // R5
  mask_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_all_i) |=> ($countones(mask_q ^ $past(mask_q)) <= 1));
endmodule

// File: rtl/vmu_vrf.sv
module vmu_vrf #(
  parameter int MVL = 16,
  parameter int EW  = 16,
  parameter int IW  = $clog2(MVL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [MVL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MVL; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int MVL = 16,
  parameter int EW  = 16,
  parameter int IW  = $clog2(MVL),
  parameter int LW  = $clog2(MVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic           mask_en_i,
  input  logic [LW-1:0]  vl_i,
  input  logic [EW-1:0]  scalar_i,
  input  logic [EW-1:0]  src_a_i,
  input  logic [EW-1:0]  src_b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [IW-1:0]  cur_idx_o,
  output logic           elem_valid_o,
  output logic [IW-1:0]  elem_idx_o,
  output logic           elem_we_o,
  output logic [EW-1:0]  elem_res_o,
  output logic [MVL-1:0] mask_o,
  input  logic [IW-1:0]  rd_idx_i,
  output logic [EW-1:0]  rd_data_o
);
  import vmu_pkg::*;

  function automatic logic [EW-1:0] elem_diff(input logic [EW-1:0] a, input logic [EW-1:0] b);
    return a - b;
  endfunction

  function automatic logic elem_ne(input logic [EW-1:0] a, input logic [EW-1:0] s);
    return (a != s);
  endfunction

  logic          accept, busy, done;
  logic [IW-1:0] idx;
  vop_e          op_q;
  logic          men_q;
  logic [EW-1:0] scal_q;
  logic [MVL-1:0] mask_q;

  // internal events named for the assertions
  logic          sub_slot, cmp_slot, sub_we, set_all;
  logic [EW-1:0] cur_diff;
  logic          cur_ne;

  vmu_seq #(.MVL(MVL), .IW(IW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .accept_o(accept), .busy_o(busy), .idx_o(idx), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= VOP_NONE;
      men_q  <= 1'b0;
      scal_q <= '0;
    end else if (accept) begin
      op_q   <= vop_e'(op_i);
      men_q  <= mask_en_i;
      scal_q <= scalar_i;
    end
  end

  assign cur_diff = elem_diff(src_a_i, src_b_i);
  assign cur_ne   = elem_ne(src_a_i, scal_q);
  assign sub_slot = busy && (op_q == VOP_SUB);
  assign cmp_slot = busy && (op_q == VOP_CMPNE);
  assign sub_we   = sub_slot && (!men_q || mask_q[idx]);
  assign set_all  = accept && (vop_e'(op_i) == VOP_SETALL);

  vmu_mask #(.MVL(MVL), .IW(IW)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_all_i(set_all),
    .upd_en_i(cmp_slot), .upd_idx_i(idx), .upd_bit_i(cur_ne),
    .mask_o(mask_q)
  );

  vmu_vrf #(.MVL(MVL), .EW(EW), .IW(IW)) u_vrf (
    .clk(clk), .rst_n(rst_n), .we_i(sub_we), .waddr_i(idx),
    .wdata_i(cur_diff), .raddr_i(rd_idx_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elem_valid_o <= 1'b0;
      elem_idx_o   <= '0;
      elem_we_o    <= 1'b0;
      elem_res_o   <= '0;
    end else begin
      elem_valid_o <= busy;
      if (busy) begin
        elem_idx_o <= idx;
        elem_we_o  <= sub_we || cmp_slot;
        if (sub_slot)      elem_res_o <= cur_diff;
        else if (cmp_slot) elem_res_o <= EW'(cur_ne);
        else               elem_res_o <= '0;
      end
    end
  end

  assign busy_o    = busy;
  assign done_o    = done;
  assign cur_idx_o = idx;
  assign mask_o    = mask_q;

  // R2
  sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_slot |=> (elem_res_o == $past(src_a_i) - $past(src_b_i)));
  // R6
  setall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_all |=> (&mask_q));
  // R3
  masked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_slot && men_q && !mask_q[idx]) |=> (elem_valid_o && !elem_we_o));
endmodule

// File: tb/vmask_unit_tb_top.sv
module vmask_unit_tb_top;
  localparam int MVL = 16, EW = 16, IW = 4, LW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, mask_en_i;
  logic [1:0] op_i;
  logic [LW-1:0] vl_i;
  logic [EW-1:0] scalar_i, src_a_i, src_b_i, elem_res_o, rd_data_o;
  logic busy_o, done_o, elem_valid_o, elem_we_o;
  logic [IW-1:0] cur_idx_o, elem_idx_o, rd_idx_i;
  logic [MVL-1:0] mask_o;

  vmask_unit #(.MVL(MVL), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mask_en_i(mask_en_i),
    .vl_i(vl_i), .scalar_i(scalar_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .busy_o(busy_o), .done_o(done_o), .cur_idx_o(cur_idx_o),
    .elem_valid_o(elem_valid_o), .elem_idx_o(elem_idx_o), .elem_we_o(elem_we_o),
    .elem_res_o(elem_res_o), .mask_o(mask_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  typedef struct { int idx; bit we; logic [EW-1:0] res; string req; } ev_t;
  ev_t exp_q[$];
  ev_t mon_e;

  int n_tests = 0, n_fail = 0;
  logic [EW-1:0] mdl_dest [MVL];
  logic [MVL-1:0] mdl_mask;
  logic [EW-1:0] sa [MVL];
  logic [EW-1:0] sb [MVL];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per reported element
  always @(negedge clk) begin
    if (rst_n === 1'b1 && elem_valid_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected element event", longint'(elem_idx_o), -1);
      end else begin
        mon_e = exp_q.pop_front();
        chk(elem_idx_o == IW'(mon_e.idx), mon_e.req, "element index", elem_idx_o, mon_e.idx);
        chk(elem_we_o == mon_e.we, mon_e.req, "element write flag", elem_we_o, mon_e.we);
        chk(elem_res_o == mon_e.res, mon_e.req, "element result", elem_res_o, mon_e.res);
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < MVL; i++) begin
      sa[i] = EW'((seed * 131 + i * 977) ^ (i << 9));
      sb[i] = EW'(seed * 53 + i * 3001 + 17);
    end
  endtask

  task automatic verify_state(input string req);
    bit ok = 1'b1;
    int bad = -1;
    for (int i = 0; i < MVL; i++) begin
      rd_idx_i = IW'(i);
      #1;
      if (rd_data_o !== mdl_dest[i]) begin ok = 1'b0; if (bad < 0) bad = i; end
    end
    chk(ok, req, "destination contents (first bad index as actual)", bad, -1);
    chk(mask_o === mdl_mask, req, "mask register", mask_o, mdl_mask);
  endtask

  task automatic run_op(input logic [1:0] op, input bit men, input int vl,
                        input logic [EW-1:0] scal, input bit poke, input string req);
    int eff = (vl > MVL) ? MVL : vl;
    bit seq_ok = 1'b1;
    ev_t e;
    @(negedge clk);
    start_i = 1'b1; op_i = op; mask_en_i = men; vl_i = LW'(vl); scalar_i = scal;
    if (op == 2'b10) mdl_mask = '1;
    for (int k = 0; k < eff; k++) begin
      e.idx = k; e.req = req;
      if (op == 2'b00) begin
        e.res = sa[k] - sb[k];
        e.we  = !men || mdl_mask[k];
        if (e.we) mdl_dest[k] = e.res;
      end else if (op == 2'b01) begin
        e.we  = 1'b1;
        e.res = EW'(sa[k] != scal);
        mdl_mask[k] = (sa[k] != scal);
      end else begin
        e.we = 1'b0; e.res = '0;
      end
      exp_q.push_back(e);
    end
    for (int k = 0; k < eff; k++) begin
      @(negedge clk);
      start_i = poke && (k == 1);
      if (poke && k == 1) op_i = 2'b10;
      src_a_i = sa[k]; src_b_i = sb[k];
      if (!(busy_o === 1'b1 && cur_idx_o === IW'(k))) seq_ok = 1'b0;
    end
    @(negedge clk);
    start_i = 1'b0;
    // R4: busy for exactly eff cycles with indices in order
    chk(seq_ok, "R4", "busy and index sequence", seq_ok, 1);
    chk(done_o === 1'b1 && busy_o === 1'b0, req, "done pulse after last element",
        {done_o, busy_o}, 2'b10);
    @(negedge clk);
    chk(done_o === 1'b0, "R4", "done lasts one cycle", done_o, 0);
    chk(exp_q.size() == 0, req, "pending element events", exp_q.size(), 0);
    verify_state(req);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b11; mask_en_i = 1'b0; vl_i = '0;
    scalar_i = '0; src_a_i = '0; src_b_i = '0; rd_idx_i = '0;
    for (int i = 0; i < MVL; i++) mdl_dest[i] = '0;
    mdl_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "busy/done after reset", {busy_o, done_o}, 0);
    verify_state("R1");

    fill(1);
    run_op(2'b00, 1'b0, 10, '0, 1'b0, "R2");

    fill(2);
    for (int i = 0; i < MVL; i += 2) sa[i] = 16'h00AB;
    run_op(2'b01, 1'b1, 16, 16'h00AB, 1'b0, "R5");

    fill(3);
    sa[1] = 16'h00AB; sa[4] = 16'h00AB;
    run_op(2'b01, 1'b0, 8, 16'h00AB, 1'b0, "R5");

    fill(4);
    run_op(2'b00, 1'b1, 16, '0, 1'b0, "R3");

    fill(5);
    run_op(2'b00, 1'b0, 12, '0, 1'b0, "R9");

    fill(6);
    run_op(2'b00, 1'b1, 16, '0, 1'b1, "R7");

    run_op(2'b10, 1'b0, 3, '0, 1'b0, "R6");

    fill(7);
    run_op(2'b00, 1'b0, 0, '0, 1'b0, "R8");
    run_op(2'b00, 1'b0, 20, '0, 1'b0, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule